// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block watches over running software. A counter advances on a chosen count source, and unless software services it in time, the block raises a one-cycle reset request toward the system reset controller. Servicing takes a two-byte unlock sequence on the service address: first 0x55, then 0xAA. Between the two bytes there may be idle cycles and writes to other addresses.

A control address accepts a single configuration write after reset. Bit 0 of that byte picks the count source: 0 selects a slow reference tick, 1 selects the bus clock. Bit 1 asks for windowed operation. The window rule applies only when the bus clock is the source. In that case, any write to the service address during the first three quarters of the period counts as a fault and forces a reset. The timeout period is a parameter given in counts.

The write port is a plain strobe with address and data. It has no ready signal, so there is no back-pressure: every strobe is taken in the cycle it appears.

Top module: `wdog_window`

## Requirements
- R1: Only the first write to address CFG_ADDR after reset takes effect. It latches bit 0 (source: 1 = bus clock) and bit 1 (window request). Every later write to that address is ignored.
- R2: After reset, the slow tick is the count source, the window is off, and rst_req is low.
- R3: When the counter reaches PERIOD-1 and takes one more count with no service, rst_req is high for exactly one cycle, on the clock edge that consumed that count, and the counter restarts from zero. With the bus clock as source, this happens PERIOD edges after the last clear.
- R4: Writing 0x55 and then 0xAA to address SVC_ADDR clears the counter to zero without a reset request.
- R5: A service write of any value other than 0x55 or 0xAA, or a 0xAA that has no 0x55 before it, discards the partial sequence and does not request a reset.
- R6: With the bus clock as source and the window on, any write to SVC_ADDR while the count is below PERIOD - PERIOD/4 drives rst_req high on the next edge and restarts the counter.
- R7: In window mode, a service sequence written while the count is at or above PERIOD - PERIOD/4 is accepted.
- R8: With the slow tick as source, the counter advances once for each rising edge of slow_tick, three bus clock edges after that edge is presented. In this mode the window bit has no effect.
- R9: If a service sequence completes in the same cycle as the terminal count, the service wins: the counter clears and no reset is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address (CFG_ADDR or SVC_ADDR) |
| wr_data | input | 8 | Write data byte |
| slow_tick | input | 1 | Slow reference tick, asynchronous |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Every cause of a reset request is a registered result. A timeout, a window fault or a cleared count shows on rst_req at the edge that samples the causing write or count, with no further delay. A slow tick reaches the counter only on the third edge after it is presented. The bench drives all inputs just after a falling edge and updates a reference model on each rising edge. At the following falling edge it compares rst_req with the model's prediction, so every expectation lines up with the exact edge on which the result becomes due.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] KEY_FIRST  = 8'h55;
  localparam logic [BYTE_W-1:0] KEY_SECOND = 8'hAA;

  typedef struct packed {
    logic win_req;  // bit 1
    logic use_bus;  // bit 0
  } wdog_cfg_t;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_ARMED = 1'b1
  } seq_state_t;
endpackage

// File: rtl/wdog_cfg_lock.sv
module wdog_cfg_lock
  import wdog_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_we,
  input  wdog_cfg_t cfg_in,
  output logic      locked,
  output wdog_cfg_t cfg_q
);
  // R1: a single write is honoured, then the lock holds until reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      cfg_q  <= '0;
    end else if (cfg_we && !locked) begin
      locked <= 1'b1;
      cfg_q  <= cfg_in;
    end
  end
endmodule

// File: rtl/wdog_tick_sync.sv
module wdog_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic tick_rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= tick_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], tick_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign tick_rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/wdog_seq.sv
module wdog_seq
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              svc_wr,
  input  logic [BYTE_W-1:0] svc_data,
  input  logic              restart,
  output logic              seq_done,
  output logic              seq_armed
);
  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (restart)     state_d = SEQ_IDLE;
    else if (svc_wr) state_d = (svc_data == KEY_FIRST) ? SEQ_ARMED : SEQ_IDLE; // R5
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  assign seq_armed = (state_q == SEQ_ARMED);
  assign seq_done  = svc_wr && (svc_data == KEY_SECOND) && seq_armed; // R4
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int PERIOD = 64,
  localparam int CNT_W = $clog2(PERIOD),
  localparam int OPEN_AT = PERIOD - PERIOD / 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             win_act,
  input  logic             svc_wr,
  input  logic             seq_done,
  output logic [CNT_W-1:0] cnt,
  output logic             restart,
  output logic             rst_req
);
  logic early, accept, at_end, expire;

  assign early   = svc_wr & win_act & (cnt < CNT_W'(OPEN_AT));   // R6
  assign accept  = seq_done & ~early;                             // R4 R7
  assign at_end  = inc & (cnt == CNT_W'(PERIOD - 1));
  assign expire  = at_end & ~accept & ~early;                     // R3, R9
  assign restart = early | expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= restart;
      if (restart || accept) cnt <= '0;
      else if (inc)          cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_window.sv
module wdog_window
  import wdog_pkg::*;
#(
  parameter int PERIOD      = 64,
  parameter int ADDR_W      = 2,
  parameter int CFG_ADDR    = 0,
  parameter int SVC_ADDR    = 1,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(PERIOD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              slow_tick,
  output logic              rst_req
);
  logic             cfg_we, svc_wr, cfg_locked, tick_rise, inc, win_act;
  logic             seq_done, seq_armed, restart;
  logic [CNT_W-1:0] cnt;
  wdog_cfg_t        cfg_in, cfg_q;

  assign cfg_we = wr_en && (wr_addr == ADDR_W'(CFG_ADDR));
  assign svc_wr = wr_en && (wr_addr == ADDR_W'(SVC_ADDR));
  assign cfg_in = wr_data[1:0];

  wdog_cfg_lock u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_in(cfg_in),
    .locked(cfg_locked), .cfg_q(cfg_q)
  );

  wdog_tick_sync #(.STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_in(slow_tick), .tick_rise(tick_rise)
  );

  // R8: window honoured only with the bus clock as source
  assign inc     = cfg_q.use_bus | tick_rise;
  assign win_act = cfg_q.use_bus & cfg_q.win_req;

  wdog_seq u_seq (
    .clk(clk), .rst_n(rst_n), .svc_wr(svc_wr), .svc_data(wr_data),
    .restart(restart), .seq_done(seq_done), .seq_armed(seq_armed)
  );

  wdog_count #(.PERIOD(PERIOD)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(inc), .win_act(win_act),
    .svc_wr(svc_wr), .seq_done(seq_done), .cnt(cnt),
    .restart(restart), .rst_req(rst_req)
  );
endmodule

// File: rtl/wdog_window_chk.sv
module wdog_window_chk #(
  parameter int PERIOD   = 64,
  parameter int ADDR_W   = 2,
  parameter int SVC_ADDR = 1,
  localparam int CNT_W   = $clog2(PERIOD),
  localparam int OPEN_AT = PERIOD - PERIOD / 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              rst_req,
  input logic [CNT_W-1:0]  cnt,
  input logic              locked,
  input logic              use_bus,
  input logic              win_req,
  input logic              armed
);
  logic svc_w;
  assign svc_w = wr_en && (wr_addr == ADDR_W'(SVC_ADDR));

  p_lock_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked && $stable(use_bus) && $stable(win_req));

  p_timeout_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (use_bus && cnt == CNT_W'(PERIOD - 1) && !svc_w) |=> rst_req);

  p_restart_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> cnt == '0);

  p_discard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_w && wr_data != 8'h55) |=> !armed);

  p_early_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_w && use_bus && win_req && cnt < CNT_W'(OPEN_AT)) |=> rst_req);

  p_service_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_w && wr_data == 8'hAA && armed && !(use_bus && win_req && cnt < CNT_W'(OPEN_AT)))
      |=> !rst_req && cnt == '0);
endmodule

bind wdog_window wdog_window_chk #(
  .PERIOD(PERIOD), .ADDR_W(ADDR_W), .SVC_ADDR(SVC_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rst_req(rst_req), .cnt(cnt), .locked(cfg_locked), .use_bus(cfg_q.use_bus),
  .win_req(cfg_q.win_req), .armed(seq_armed)
);

// File: tb/sim_wdog_window.sv
module sim_wdog_window;
  localparam int PER  = 64;
  localparam int OPEN = PER - PER / 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0, wr_en = 1'b0, slow_tick = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rst_req;

  int    checks = 0, errors = 0, cycles = 0;
  string phase = "init";

  // reference model state
  logic  m_sel = 0, m_win = 0, m_lock = 0, m_armed = 0, m_rst = 0;
  int    m_cnt = 0;
  logic [2:0] sh = '0;
  string m_tag = "R2";

  always #2 clk = ~clk;

  wdog_window u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .slow_tick(slow_tick), .rst_req(rst_req)
  );

  // model of the requirements, advanced on each rising edge
  always @(posedge clk) begin
    logic win, pulse, inc, svcw, cfgw, fault, ok, tmo;
    if (!rst_n) begin
      m_sel = 0; m_win = 0; m_lock = 0; m_armed = 0; m_rst = 0; m_cnt = 0; sh = '0;
      m_tag = "R2";
    end else begin
      win   = m_sel & m_win;                       // R8: window needs bus source
      pulse = sh[1] & ~sh[2];
      inc   = m_sel | pulse;
      svcw  = wr_en && wr_addr == 2'd1;
      cfgw  = wr_en && wr_addr == 2'd0;
      fault = svcw && win && m_cnt < OPEN;          // R6
      ok    = svcw && !fault && wr_data == 8'hAA && m_armed;
      tmo   = inc && m_cnt == PER - 1 && !ok && !fault;
      if (fault)                          m_tag = "R6";
      else if (tmo)                       m_tag = "R3";
      else if (ok && inc && m_cnt == PER-1) m_tag = "R9";
      else if (ok)                        m_tag = win ? "R7" : "R4";
      else if (svcw)                      m_tag = "R5";
      else if (!m_sel)                    m_tag = "R8";
      else                                m_tag = "R1";
      m_rst = fault | tmo;
      if (fault | ok | tmo) m_cnt = 0;
      else if (inc)         m_cnt = m_cnt + 1;
      if (fault | tmo)      m_armed = 0;
      else if (svcw)        m_armed = (wr_data == 8'h55);
      if (cfgw && !m_lock) begin
        m_sel = wr_data[0]; m_win = wr_data[1]; m_lock = 1;
      end
      sh = {sh[1], sh[0], slow_tick};
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (rst_req !== m_rst) begin
        errors++;
        $display("FAIL %s [%s]: rst_req=%0b expected %0b", m_tag, phase, rst_req, m_rst);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run did not end, cycles=%0d expected <150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic cyc(input logic we, input logic [1:0] a, input logic [7:0] d);
    wr_en = we; wr_addr = a; wr_data = d;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 8'h00);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      slow_tick = 1'b1; idle(2);
      slow_tick = 1'b0; idle(2);
    end
  endtask

  task automatic do_reset;
    rst_n = 1'b0; wr_en = 1'b0; slow_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;                                       // R2: quiet after reset
    if (rst_req !== 1'b0) begin
      errors++;
      $display("FAIL R2: rst_req=%0b expected 0 after reset", rst_req);
    end
  endtask

  task automatic wait_cnt(input int v);
    while (m_cnt != v) cyc(1'b0, 2'd0, 8'h00);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);

    // R2/R8: default slow source, no ticks means no timeout
    phase = "slow default";
    do_reset();
    idle(30);
    cyc(1, 2'd1, 8'h55); cyc(1, 2'd1, 8'hAA);     // R4 in slow mode
    ticks(PER + 3);                                // R3 through slow ticks
    idle(5);

    // R1: second config write ignored; R8: window bit without bus source
    phase = "R1 write-once";
    do_reset();
    cyc(1, 2'd0, 8'h02);
    cyc(1, 2'd0, 8'h03);
    idle(4);
    cyc(1, 2'd1, 8'h55);                           // early, but no fault
    ticks(6);
    idle(20);

    // bus source, normal mode
    phase = "bus normal";
    do_reset();
    cyc(1, 2'd0, 8'h01);
    idle(PER + 5);                                 // R3 timeout
    cyc(1, 2'd1, 8'hAA);                           // R5 lone second byte
    cyc(1, 2'd1, 8'h55); cyc(1, 2'd1, 8'h12); cyc(1, 2'd1, 8'hAA); // R5
    cyc(1, 2'd1, 8'h55); cyc(1, 2'd2, 8'hAA); idle(3); cyc(1, 2'd1, 8'hAA); // R4
    wait_cnt(PER - 3);
    cyc(1, 2'd1, 8'h55); idle(1); cyc(1, 2'd1, 8'hAA); // R9 service at terminal count
    idle(PER + 2);

    // bus source, window mode
    phase = "window";
    do_reset();
    cyc(1, 2'd0, 8'h03);
    idle(3);
    cyc(1, 2'd1, 8'h55);                           // R6 early fault
    wait_cnt(OPEN - 1);
    cyc(1, 2'd1, 8'h55);                           // R6 boundary fault
    wait_cnt(OPEN);
    cyc(1, 2'd1, 8'h55); cyc(1, 2'd1, 8'hAA);     // R7 accepted
    wait_cnt(PER - 2);
    cyc(1, 2'd1, 8'h55); cyc(1, 2'd1, 8'hAA);     // R7 late service
    idle(PER + 2);

    // constrained random rounds
    for (int r = 0; r < 8; r++) begin
      phase = $sformatf("random %0d", r);
      do_reset();
      cyc(1, 2'd0, 8'($urandom % 4));
      for (int i = 0; i < 2500; i++) begin
        int k;
        k = $urandom % 100;
        if ($urandom % 6 == 0) slow_tick = ~slow_tick;
        if (k < 6) begin
          int s;
          s = $urandom % 4;
          cyc(1, 2'($urandom % 4), s == 0 ? 8'h55 : s == 1 ? 8'hAA : 8'($urandom));
        end else if (k < 10 && m_cnt >= OPEN) begin
          cyc(1, 2'd1, 8'h55); cyc(1, 2'd1, 8'hAA);
        end else begin
          cyc(0, 2'd0, 8'h00);
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule